// File: doc/BRIEF.md
# Serial EEPROM Word Transfer Engine

This block drives a serial EEPROM over a four-wire SPI link in mode 0 (SCK idles low, data is captured on the rising edge, MSB first). It moves a run of 16-bit words in either direction, starting at a word offset that the host gives. The host sets the direction, offset, word count, device size, address width (8 or 16 address bits) and page size, then pulses `start`. The engine reports completion with a one-cycle `done` pulse, and raises `err` in the same cycle if the request failed.

The engine turns word offsets into byte addresses and asks the device for its status before each command sequence. Reads are a single streamed command. Writes are cut into bursts that never cross a page. For devices with 8 address bits, the ninth address bit travels inside the opcode. Byte order on the wire is low byte first, in both directions. Write data is taken one word at a time: the `wd_take` pulse tells the host to present the next word. Read data leaves as one `rd_valid` pulse per word.

Top module: `spi_eeprom_xfer`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, and `busy`, `done` and `err` are 0.
- R2: A request is rejected without selecting the device (`cs_n` never falls), with `done` and `err` together, in any of these cases: `word_ofs >= dev_words`, `word_cnt == 0`, or `word_cnt > dev_words - word_ofs`.
- R3: Before every command sequence the engine sends the status-read opcode 0x05 and clocks in 8 bits. While bit 0 of that byte is 1 (busy), it pulses chip select high and then low again (a standby) and repeats the status read.
- R4: If the status read returns busy `MAX_POLL` times in a row, the engine stops, leaves `cs_n` high and ends with `done` and `err`.
- R5: A read sends opcode 0x03, then the byte address `2*word_ofs` (16 bits when `addr16`=1, else its low 8 bits), MSB first, with SCK low while idle.
- R6: With `addr16`=0, a command whose first word offset is 128 or more has 0x08 ORed into its opcode (read 0x0B, write 0x0A).
- R7: A read streams all words after one command. The first byte received becomes bits 7:0 of `rdata` and the second byte becomes bits 15:8. Each word leaves with a one-cycle `rd_valid`, in address order.
- R8: Each write burst sends the write-enable opcode 0x06, a standby, opcode 0x02 and the byte address, then each word low byte first. `wd_take` pulses once for each word consumed.
- R9: A write burst ends after the word that makes `(word_ofs + words written) * 2` a multiple of `page_bytes` (a power of two). The engine then does a standby, polls for ready, and restarts with write-enable and write at the next address.
- R10: MOSI is held at 1 whenever the engine is clocking in data bits.
- R11: `done` is a single-cycle pulse, `busy` is 0 while `done` is 1, and `err` is 1 only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken while idle) |
| write_en | input | 1 | 1 = write, 0 = read |
| addr16 | input | 1 | 1 = 16 address bits, 0 = 8 address bits |
| word_ofs | input | AW | First word offset |
| word_cnt | input | AW | Number of words |
| dev_words | input | AW | Device size in words |
| page_bytes | input | AW | Write page size in bytes, power of two |
| wdata | input | 16 | Next word to write |
| wd_take | output | 1 | Pulse: current `wdata` consumed |
| rd_valid | output | 1 | Pulse: `rdata` holds a read word |
| rdata | output | 16 | Read word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Pulse: transfer finished |
| err | output | 1 | With `done`: request failed |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The hardest case to reach from the ports is a write that crosses a page boundary while the device still reports busy from the previous burst. The restart must then wait through several status reads before write-enable is sent again. The bench reaches this with a behavioural EEPROM model that holds its busy bit set for two status reads after every completed write. It uses an 8-byte page and a run of five words that starts mid-page. A second write at word offset 127 in 8-bit mode splits right at the point where the ninth address bit must appear in the opcode.

// File: rtl/spi_eeprom_xfer.sv
module spi_eeprom_xfer #(
  parameter int AW       = 16,
  parameter int HALF_DIV = 2,
  parameter int MAX_POLL = 16,
  parameter int STBY_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          write_en,
  input  logic          addr16,
  input  logic [AW-1:0] word_ofs,
  input  logic [AW-1:0] word_cnt,
  input  logic [AW-1:0] dev_words,
  input  logic [AW-1:0] page_bytes,
  input  logic [15:0]   wdata,
  output logic          wd_take,
  output logic          rd_valid,
  output logic [15:0]   rdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          cs_n,
  output logic          sck,
  output logic          mosi,
  input  logic          miso
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int PW = $clog2(MAX_POLL + 1);
  localparam int SW = $clog2(STBY_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_POLL_OP, S_POLL_RX, S_POLL_EV, S_STBY,
    S_WREN, S_CMD, S_ADDR, S_RD, S_WR, S_END
  } st_t;

  st_t st, ret_st;
  logic wr_q, a16_q, fail, armed;
  logic [AW-1:0] ofs_q, cnt_q, pg_q, idx;
  logic [PW-1:0] tries;
  logic [SW-1:0] scnt;
  logic sh_busy, rx_mode, sck_q, cs_q;
  logic [15:0] tx_sr, rx_sr, rdata_q;
  logic [4:0] nbits;
  logic [DW-1:0] dcnt;
  logic done_q, err_q, rdv_q, take_q;

  logic [AW-1:0] cur, cur_nx;
  logic [AW:0] byte_addr, next_byte, pg_mask;
  logic a8, last, page_hit, shifting, go, sh_done;
  logic [15:0] go_data;
  logic go_len16, go_rx;

  assign cur       = ofs_q + idx;
  assign cur_nx    = cur + AW'(1);
  assign byte_addr = {cur, 1'b0};
  assign next_byte = {cur_nx, 1'b0};
  assign pg_mask   = {1'b0, pg_q} - (AW+1)'(1);
  assign page_hit  = (next_byte & pg_mask) == '0;
  assign a8        = !a16_q && (cur >= AW'(128));
  assign last      = idx == cnt_q - AW'(1);
  assign shifting  = st inside {S_POLL_OP, S_POLL_RX, S_WREN, S_CMD, S_ADDR, S_RD, S_WR};
  assign go        = shifting && !armed;
  assign sh_done   = armed && !sh_busy;

  always_comb begin
    go_data  = 16'h0000;
    go_len16 = 1'b0;
    go_rx    = 1'b0;
    case (st)
      S_POLL_OP: go_data = 16'h0500;
      S_POLL_RX: go_rx = 1'b1;
      S_WREN:    go_data = 16'h0600;
      S_CMD:     go_data = {(wr_q ? 8'h02 : 8'h03) | (a8 ? 8'h08 : 8'h00), 8'h00};
      S_ADDR: begin
        go_len16 = a16_q;
        go_data  = a16_q ? byte_addr[15:0] : {byte_addr[7:0], 8'h00};
      end
      S_RD: begin
        go_rx    = 1'b1;
        go_len16 = 1'b1;
      end
      S_WR: begin
        go_len16 = 1'b1;
        go_data  = {wdata[7:0], wdata[15:8]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_busy <= 1'b0;
      rx_mode <= 1'b0;
      sck_q   <= 1'b0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      nbits   <= '0;
      dcnt    <= '0;
    end else if (go) begin
      sh_busy <= 1'b1;
      rx_mode <= go_rx;
      sck_q   <= 1'b0;
      tx_sr   <= go_data;
      nbits   <= go_len16 ? 5'd16 : 5'd8;
      dcnt    <= '0;
    end else if (sh_busy) begin
      if (dcnt == DW'(HALF_DIV - 1)) begin
        dcnt <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_sr <= {rx_sr[14:0], miso};
        end else begin
          sck_q <= 1'b0;
          tx_sr <= {tx_sr[14:0], 1'b0};
          nbits <= nbits - 5'd1;
          if (nbits == 5'd1) sh_busy <= 1'b0;
        end
      end else begin
        dcnt <= dcnt + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ret_st  <= S_IDLE;
      wr_q    <= 1'b0;
      a16_q   <= 1'b0;
      ofs_q   <= '0;
      cnt_q   <= '0;
      pg_q    <= '0;
      idx     <= '0;
      tries   <= '0;
      scnt    <= '0;
      fail    <= 1'b0;
      armed   <= 1'b0;
      cs_q    <= 1'b1;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdv_q   <= 1'b0;
      take_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rdv_q  <= 1'b0;
      take_q <= 1'b0;
      if (go) begin
        armed <= 1'b1;
        if (st == S_WR) take_q <= 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          wr_q  <= write_en;
          a16_q <= addr16;
          ofs_q <= word_ofs;
          cnt_q <= word_cnt;
          pg_q  <= page_bytes;
          idx   <= '0;
          tries <= '0;
          fail  <= 1'b0;
          if ((word_ofs >= dev_words) || (word_cnt == '0) ||
              (word_cnt > dev_words - word_ofs)) begin
            fail <= 1'b1;
            st   <= S_END;
          end else begin
            cs_q <= 1'b0;
            st   <= S_POLL_OP;
          end
        end
        S_POLL_OP: if (sh_done) begin
          armed <= 1'b0;
          st    <= S_POLL_RX;
        end
        S_POLL_RX: if (sh_done) begin
          armed <= 1'b0;
          st    <= S_POLL_EV;
        end
        S_POLL_EV: begin
          if (!rx_sr[0]) begin
            ret_st <= wr_q ? S_WREN : S_CMD;
            cs_q   <= 1'b1;
            scnt   <= '0;
            st     <= S_STBY;
          end else if (tries == PW'(MAX_POLL - 1)) begin
            fail <= 1'b1;
            st   <= S_END;
          end else begin
            tries  <= tries + PW'(1);
            ret_st <= S_POLL_OP;
            cs_q   <= 1'b1;
            scnt   <= '0;
            st     <= S_STBY;
          end
        end
        S_STBY: begin
          if (scnt == SW'(STBY_CYC - 1)) begin
            cs_q <= 1'b0;
            st   <= ret_st;
          end else begin
            scnt <= scnt + SW'(1);
          end
        end
        S_WREN: if (sh_done) begin
          armed  <= 1'b0;
          ret_st <= S_CMD;
          cs_q   <= 1'b1;
          scnt   <= '0;
          st     <= S_STBY;
        end
        S_CMD: if (sh_done) begin
          armed <= 1'b0;
          st    <= S_ADDR;
        end
        S_ADDR: if (sh_done) begin
          armed <= 1'b0;
          st    <= wr_q ? S_WR : S_RD;
        end
        S_RD: if (sh_done) begin
          armed   <= 1'b0;
          rdata_q <= {rx_sr[7:0], rx_sr[15:8]};
          rdv_q   <= 1'b1;
          idx     <= idx + AW'(1);
          if (last) st <= S_END;
        end
        S_WR: if (sh_done) begin
          armed <= 1'b0;
          idx   <= idx + AW'(1);
          if (last) begin
            st <= S_END;
          end else if (page_hit) begin
            tries  <= '0;
            ret_st <= S_POLL_OP;
            cs_q   <= 1'b1;
            scnt   <= '0;
            st     <= S_STBY;
          end
        end
        S_END: begin
          cs_q   <= 1'b1;
          done_q <= 1'b1;
          err_q  <= fail;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = st != S_IDLE;
  assign done     = done_q;
  assign err      = err_q;
  assign rd_valid = rdv_q;
  assign wd_take  = take_q;
  assign rdata    = rdata_q;
  assign cs_n     = cs_q;
  assign sck      = sck_q;
  assign mosi     = (sh_busy && !rx_mode) ? tx_sr[15] : 1'b1;
endmodule

module spi_eeprom_xfer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic rd_valid,
  input logic wd_take,
  input logic cs_n,
  input logic sck
);
  p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck));
  p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_sck_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> !cs_n);
  p_one_direction_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wd_take));
  p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind spi_eeprom_xfer spi_eeprom_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .rd_valid(rd_valid), .wd_take(wd_take), .cs_n(cs_n), .sck(sck)
);

// File: tb/tb_spi_eeprom_xfer.sv
module tb_spi_eeprom_xfer;
  localparam int MAXP = 16;
  logic clk = 0, rst_n = 0, start = 0, write_en = 0, addr16 = 1;
  logic [15:0] word_ofs = 0, word_cnt = 0, dev_words = 0, page_bytes = 16;
  logic [15:0] wdata, rdata;
  logic wd_take, rd_valid, busy, done, err, cs_n, sck, mosi;
  logic miso = 0;
  logic [15:0] wbuf [0:7];
  logic [15:0] rbuf [0:7];
  int widx = 0, ridx = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;
  assign wdata = wbuf[widx & 7];

  spi_eeprom_xfer #(.AW(16), .HALF_DIV(2), .MAX_POLL(MAXP), .STBY_CYC(4)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .write_en(write_en), .addr16(addr16),
    .word_ofs(word_ofs), .word_cnt(word_cnt), .dev_words(dev_words),
    .page_bytes(page_bytes), .wdata(wdata), .wd_take(wd_take), .rd_valid(rd_valid),
    .rdata(rdata), .busy(busy), .done(done), .err(err), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  always @(negedge clk) begin
    if (wd_take) widx = widx + 1;
    if (rd_valid) begin
      rbuf[ridx & 7] = rdata;
      ridx = ridx + 1;
    end
  end

  // Behavioural EEPROM model
  logic [7:0] mem [0:1023];
  logic [7:0] insh = 0, outsh = 0;
  int bitn = 0, op = 0, hdr_left = 0, maddr = 0, busy_left = 0;
  bit rd_ph = 0, wr_ph = 0, out_ph = 0, wrote = 0;
  int n_sel = 0, n_rdsr = 0, n_wren = 0, n_wrcmd = 0, n_rdcmd = 0, mosi_bad = 0;
  int last_rd_op = 0, last_rd_addr = 0, last_wr_op = 0;
  int wr_addr_log [0:3];

  task automatic handle_byte();
    if (bitn == 8) begin
      op = insh;
      if (op == 8'h05) begin
        n_rdsr++;
        outsh = (busy_left > 0) ? 8'h01 : 8'h00;
        if (busy_left > 0) busy_left--;
        out_ph = 1;
      end else if (op == 8'h06) begin
        n_wren++;
      end else if (op == 8'h03 || op == 8'h0B || op == 8'h02 || op == 8'h0A) begin
        hdr_left = addr16 ? 2 : 1;
        maddr = (!addr16 && (op & 8)) ? 256 : 0;
        if (op & 1) begin n_rdcmd++; last_rd_op = op; end
        else begin n_wrcmd++; last_wr_op = op; end
      end
    end else if (hdr_left > 0) begin
      maddr = addr16 ? ((maddr << 8) | insh) : (maddr | insh);
      hdr_left--;
      if (hdr_left == 0) begin
        if (op & 1) begin
          last_rd_addr = maddr;
          rd_ph = 1; out_ph = 1;
          outsh = mem[maddr % 1024];
          maddr++;
        end else begin
          wr_addr_log[(n_wrcmd - 1) & 3] = maddr;
          wr_ph = 1;
        end
      end
    end else if (rd_ph) begin
      outsh = mem[maddr % 1024];
      maddr++;
    end else if (wr_ph) begin
      mem[maddr % 1024] = insh;
      maddr++;
      wrote = 1;
    end
  endtask

  always @(negedge cs_n) begin
    n_sel++; bitn = 0; rd_ph = 0; wr_ph = 0; out_ph = 0; hdr_left = 0;
  end
  always @(posedge cs_n) if (wrote) begin busy_left = 2; wrote = 0; end
  always @(posedge sck) if (!cs_n) begin
    if (out_ph && mosi !== 1'b1) mosi_bad++;
    insh = {insh[6:0], mosi};
    bitn++;
    if (bitn % 8 == 0) handle_byte();
  end
  always @(negedge sck) if (!cs_n) begin
    miso = outsh[7];
    outsh = {outsh[6:0], 1'b0};
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    n_sel = 0; n_rdsr = 0; n_wren = 0; n_wrcmd = 0; n_rdcmd = 0;
    busy_left = 0; wrote = 0; last_rd_op = 0; last_rd_addr = -1; last_wr_op = 0;
    for (int i = 0; i < 4; i++) wr_addr_log[i] = -1;
  endtask

  task automatic run(input bit w, input int ofs, input int cnt, input int dw,
                     input int pg, input bit a16, output bit e);
    int n;
    @(negedge clk);
    write_en = w; word_ofs = 16'(ofs); word_cnt = 16'(cnt); dev_words = 16'(dw);
    page_bytes = 16'(pg); addr16 = a16; widx = 0; ridx = 0; start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 60000) begin @(negedge clk); n++; end
    if (!done) chk("R11 done timeout", 0, 1);
    e = err;
    chk("R11 busy low with done", busy, 0);
    @(negedge clk);
    chk("R11 done single pulse", done, 0);
  endtask

  task automatic t_reset();
    chk("R1 cs_n", cs_n, 1); chk("R1 sck", sck, 0);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
  endtask

  task automatic t_range();
    bit e;
    clear_log();
    run(0, 512, 1, 512, 16, 1, e); chk("R2 offset too large err", e, 1);
    run(0, 0, 0, 512, 16, 1, e);   chk("R2 zero count err", e, 1);
    run(1, 510, 3, 512, 16, 1, e); chk("R2 count past end err", e, 1);
    chk("R2 no device select", n_sel, 0);
  endtask

  task automatic t_read16();
    bit e;
    clear_log();
    run(0, 5, 3, 512, 16, 1, e);
    chk("R7 read err", e, 0);
    chk("R3 one status read when ready", n_rdsr, 1);
    chk("R5 read opcode", last_rd_op, 8'h03);
    chk("R5 byte address 2*offset", last_rd_addr, 10);
    chk("R7 single read command", n_rdcmd, 1);
    chk("R7 word count", ridx, 3);
    for (int k = 0; k < 3; k++)
      chk("R7 word low byte first", rbuf[k], {mem[11 + 2*k], mem[10 + 2*k]});
    chk("R10 mosi high while receiving", mosi_bad, 0);
  endtask

  task automatic t_read8();
    bit e;
    clear_log();
    run(0, 130, 2, 256, 16, 0, e);
    chk("R6 read err", e, 0);
    chk("R6 read opcode with ninth bit", last_rd_op, 8'h0B);
    chk("R6 decoded address", last_rd_addr, 260);
    chk("R7 word0 8-bit mode", rbuf[0], {mem[261], mem[260]});
    chk("R7 word1 8-bit mode", rbuf[1], {mem[263], mem[262]});
  endtask

  task automatic t_poll();
    bit e;
    clear_log();
    busy_left = 3;
    run(0, 0, 1, 512, 16, 1, e);
    chk("R3 polled until ready err", e, 0);
    chk("R3 status reads", n_rdsr, 4);
    chk("R3 data after ready", rbuf[0], {mem[1], mem[0]});
  endtask

  task automatic t_timeout();
    bit e;
    clear_log();
    busy_left = 1000;
    run(0, 0, 1, 512, 16, 1, e);
    chk("R4 timeout err", e, 1);
    chk("R4 status reads", n_rdsr, MAXP);
    chk("R4 no read command", n_rdcmd, 0);
    chk("R4 cs_n high", cs_n, 1);
    busy_left = 0;
  endtask

  task automatic t_write_split();
    bit e;
    clear_log();
    for (int k = 0; k < 8; k++) wbuf[k] = 16'hA100 + 16'(k * 16'h0111);
    run(1, 2, 5, 512, 8, 1, e);
    chk("R8 write err", e, 0);
    chk("R8 words taken", widx, 5);
    chk("R9 write-enable per burst", n_wren, 2);
    chk("R9 write commands", n_wrcmd, 2);
    chk("R9 first burst address", wr_addr_log[0], 4);
    chk("R9 second burst address", wr_addr_log[1], 8);
    chk("R9 polls across split", n_rdsr, 4);
    for (int k = 0; k < 5; k++) begin
      chk("R8 low byte stored first", mem[4 + 2*k], wbuf[k][7:0]);
      chk("R8 high byte stored second", mem[5 + 2*k], wbuf[k][15:8]);
    end
  endtask

  task automatic t_write_a8();
    bit e;
    clear_log();
    wbuf[0] = 16'h1234; wbuf[1] = 16'hBEEF;
    run(1, 127, 2, 256, 16, 0, e);
    chk("R6 write err", e, 0);
    chk("R9 split at 128", n_wrcmd, 2);
    chk("R6 first burst address", wr_addr_log[0], 254);
    chk("R6 second burst opcode", last_wr_op, 8'h0A);
    chk("R6 second burst address", wr_addr_log[1], 256);
    chk("R8 word at 127", {mem[255], mem[254]}, 16'h1234);
    chk("R6 word at 128", {mem[257], mem[256]}, 16'hBEEF);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 3));
    for (int k = 0; k < 8; k++) begin wbuf[k] = 0; rbuf[k] = 0; end
    clear_log();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_range();
    t_read16();
    t_read8();
    t_poll();
    t_timeout();
    t_write_split();
    t_write_a8();
    chk("R10 mosi high while receiving (all)", mosi_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule